// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block watches over software. A free-running up-counter advances on every clock. When it reaches the interval that software has chosen, one of two things happens. In watchdog mode the block emits a one-cycle system reset. In interval mode it raises an interrupt flag and starts counting again. Software keeps the watchdog from firing by rewriting the control byte with the clear bit set. The counter cannot be read or loaded directly.

Every write on the 16-bit write port must carry the key byte 0x5A in bits 15:8. Bits 7:0 then become the new control byte. A write with any other upper byte is rejected, and it triggers the same system reset as an expired watchdog. The read port always shows the signature byte 0x69 in bits 15:8 and the stored control byte in bits 7:0. The write port is a valid/ready stream. A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only during the cycle in which the reset pulse is being driven. A source that sees `wr_ready` low must hold its word until the next cycle. Two control bits only pass through to pins that configure an external non-maskable interrupt input. Two sticky flags record which event caused the last reset. Only the power-on reset `rst_n` clears them.

The control byte is laid out as follows. Bits 1:0 select the interval: 00 gives 2^15 cycles, 01 gives 2^13, 10 gives 2^9 and 11 gives 2^6. Bit 2 clears the counter. Bit 3 selects the mode: 0 for watchdog, 1 for interval. Bit 4 holds the counter. Bit 5 is the NMI enable. Bit 6 is the NMI edge select. Bit 7 is stored with no other effect.

Top module: `wdog_guard`

## Requirements
- R1: A word accepted with bits 15:8 equal to 0x5A stores bits 7:0 as the control byte. From the next cycle, `rd_data[7:0]` shows that byte with bit 2 forced to 0.
- R2: A word accepted with any other value in bits 15:8 drives `sys_rst_o` high on the next cycle and sets `cause_key_o`. It leaves the control byte unchanged.
- R3: `rd_data[15:8]` is always 0x69.
- R4: Writing a control byte with bit 2 set restarts the counter from zero on the accepting edge. Bit 2 always reads back as 0.
- R5: While bit 4 (hold) is set, the counter does not advance and no expiry occurs. Counting resumes once hold is cleared.
- R6: After a restart, the counter expires 2^T cycles later, where T is 15, 13, 9 or 6 for bits 1:0 equal to 00, 01, 10 or 11.
- R7: In watchdog mode (bit 3 = 0), expiry drives `sys_rst_o` high on the expiring edge and sets `cause_expire_o`.
- R8: In interval mode (bit 3 = 1), expiry sets `irq_o` and does not reset the system. The counter restarts. `irq_o` stays high until `irq_ack` is sampled high.
- R9: `sys_rst_o` is high for exactly one cycle. On the following edge the control byte becomes 0x00 (watchdog, running, longest interval) and the counter restarts.
- R10: `nmi_en_o` follows control bit 5, and `nmi_edge_o` follows control bit 6.
- R11: `wr_ready` is low while `sys_rst_o` is high. `cause_key_o` and `cause_expire_o` stay set until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears everything including cause flags |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word can be taken this cycle |
| wr_data | input | 16 | Key in bits 15:8, control byte in bits 7:0 |
| rd_data | output | 16 | Signature 0x69 in bits 15:8, control byte in bits 7:0 |
| irq_ack | input | 1 | Clears the interval interrupt flag |
| irq_o | output | 1 | Interval-mode interrupt flag |
| sys_rst_o | output | 1 | One-cycle system reset request |
| nmi_en_o | output | 1 | NMI function enable (control bit 5) |
| nmi_edge_o | output | 1 | NMI edge select (control bit 6) |
| cause_key_o | output | 1 | Sticky: a bad key caused a reset |
| cause_expire_o | output | 1 | Sticky: watchdog expiry caused a reset |

## Verification
The assertions assume that the write source obeys the handshake. A word offered while `wr_ready` is low is not taken, and the source holds it there. They also assume that `irq_ack` is a clean synchronous level, and that `rst_n` is only released between clock edges. The stimulus meets these assumptions in the following ways:
- It changes every input at the falling edge.
- It offers each word for exactly one cycle, and only when no reset pulse is pending.
- It raises `irq_ack` for single cycles, and only after the flag has been observed.

Wrong-key words are sent deliberately, to exercise the reset path.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Control byte layout; field positions are decoded by the counter and pins.
  typedef struct packed {
    logic       spare;     // bit 7: stored only
    logic       nmi_edge;  // bit 6
    logic       nmi_en;    // bit 5
    logic       hold;      // bit 4
    logic       mode_iv;   // bit 3: 1 = interval mode
    logic       restart;   // bit 2: write-only clear
    logic [1:0] sel;       // bits 1:0: interval select
  } ctrl_t;

  localparam logic [7:0] RESTART_MASK = 8'hFB;

endpackage

// File: rtl/wdog_keyport.sv
module wdog_keyport #(
  parameter logic [7:0] KEY_BYTE = 8'h5A
) (
  input  logic        wr_valid,
  input  logic [15:0] wr_data,
  input  logic        busy_i,
  output logic        wr_ready,
  output logic        accept_o,
  output logic        bad_o,
  output wdog_pkg::ctrl_t byte_o
);

  logic take;

  assign wr_ready = !busy_i;
  assign take     = wr_valid && !busy_i;
  assign accept_o = take && (wr_data[15:8] == KEY_BYTE);
  assign bad_o    = take && (wr_data[15:8] != KEY_BYTE);
  assign byte_o   = wdog_pkg::ctrl_t'(wr_data[7:0]);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TAP_A = 15,
  parameter int unsigned TAP_B = 13,
  parameter int unsigned TAP_C = 9,
  parameter int unsigned TAP_D = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       hold_i,
  input  logic [1:0] sel_i,
  output logic       expire_o
);

  localparam int unsigned NTAP = 4;
  localparam int unsigned TAPS [NTAP] = '{TAP_A, TAP_B, TAP_C, TAP_D};

  logic [CNT_W-1:0] cnt_q;
  logic [NTAP-1:0]  hit;

  // A tap fires when all bits below it are ones: 2^T cycles from zero.
  for (genvar gi = 0; gi < NTAP; gi++) begin : g_tap
    assign hit[gi] = &cnt_q[TAPS[gi]-1:0];
  end

  assign expire_o = !hold_i && hit[sel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (expire_o)  cnt_q <= '0;
    else if (!hold_i)   cnt_q <= cnt_q + 1'b1;
  end

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int unsigned CNT_W    = 16,
  parameter logic [7:0]  KEY_BYTE = 8'h5A,
  parameter logic [7:0]  SIG_BYTE = 8'h69,
  parameter int unsigned TAP_A    = 15,
  parameter int unsigned TAP_B    = 13,
  parameter int unsigned TAP_C    = 9,
  parameter int unsigned TAP_D    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        irq_ack,
  output logic        irq_o,
  output logic        sys_rst_o,
  output logic        nmi_en_o,
  output logic        nmi_edge_o,
  output logic        cause_key_o,
  output logic        cause_expire_o
);

  import wdog_pkg::*;

  ctrl_t ctrl_q, wr_byte;
  logic  pulse_q, irq_q, ck_q, ce_q;
  logic  accept, bad, expire, wd_fire, iv_fire, cnt_clr;

  wdog_keyport #(.KEY_BYTE(KEY_BYTE)) u_key (
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .busy_i   (pulse_q),
    .wr_ready (wr_ready),
    .accept_o (accept),
    .bad_o    (bad),
    .byte_o   (wr_byte)
  );

  assign cnt_clr = (accept && wr_byte.restart) || pulse_q;

  wdog_counter #(
    .CNT_W(CNT_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .TAP_C(TAP_C), .TAP_D(TAP_D)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (cnt_clr),
    .hold_i   (ctrl_q.hold),
    .sel_i    (ctrl_q.sel),
    .expire_o (expire)
  );

  assign wd_fire = expire && !ctrl_q.mode_iv && !pulse_q;
  assign iv_fire = expire &&  ctrl_q.mode_iv && !pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
      ck_q    <= 1'b0;
      ce_q    <= 1'b0;
    end else begin
      pulse_q <= !pulse_q && (bad || wd_fire);
      ck_q    <= ck_q || bad;
      ce_q    <= ce_q || wd_fire;
      if (pulse_q)      ctrl_q <= '0;
      else if (accept)  ctrl_q <= ctrl_t'(wr_byte & RESTART_MASK);
      if (pulse_q)      irq_q <= 1'b0;
      else if (iv_fire) irq_q <= 1'b1;
      else if (irq_ack) irq_q <= 1'b0;
    end
  end

  assign rd_data        = {SIG_BYTE, ctrl_q};
  assign irq_o          = irq_q;
  assign sys_rst_o      = pulse_q;
  assign nmi_en_o       = ctrl_q.nmi_en;
  assign nmi_edge_o     = ctrl_q.nmi_edge;
  assign cause_key_o    = ck_q;
  assign cause_expire_o = ce_q;

  assert_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_data[15:8] == KEY_BYTE)
      |=> (rd_data[7:0] == ($past(wr_data[7:0]) & RESTART_MASK)));

  assert_bad_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_data[15:8] != KEY_BYTE) |=> sys_rst_o);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);

  assert_ctrl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> (rd_data[7:0] == 8'h00));

  assert_ready_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> !wr_ready);

  assert_sticky_key_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cause_key_o |=> cause_key_o);

  assert_sticky_exp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cause_expire_o |=> cause_expire_o);

endmodule

// File: tb/wdog_guard_tb.sv
`timescale 1ns/1ps
module wdog_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq_ack = 1'b0;
  logic        irq_o, sys_rst_o, nmi_en_o, nmi_edge_o, cause_key_o, cause_expire_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [15:0] exp;
    string       req;
  } rd_item_t;
  rd_item_t sbq[$];

  always #2.5 clk = ~clk;

  wdog_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_data(rd_data), .irq_ack(irq_ack), .irq_o(irq_o),
    .sys_rst_o(sys_rst_o), .nmi_en_o(nmi_en_o), .nmi_edge_o(nmi_edge_o),
    .cause_key_o(cause_key_o), .cause_expire_o(cause_expire_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Monitor: pops expected readbacks and compares between edges.
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        rd_item_t it;
        it = sbq.pop_front();
        chk(rd_data == it.exp, it.req, "readback", rd_data, it.exp);
      end
    end
  end

  // Driver: one-cycle write, then queue the expected readback.
  task automatic wr(input logic [15:0] d, input logic [15:0] exp_rd, input string req);
    rd_item_t it;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
    it.exp = exp_rd;
    it.req = req;
    sbq.push_back(it);
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(posedge clk);
    #1;
    irq_ack = 1'b0;
  endtask

  task automatic until_irq(output int n);
    n = 0;
    do begin
      @(posedge clk);
      #1;
      n++;
    end while (!irq_o && n < 40000);
  endtask

  task automatic until_rst(output int n);
    n = 0;
    do begin
      @(posedge clk);
      #1;
      n++;
    end while (!sys_rst_o && n < 40000);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=120000 cycles expected=fewer");
    finish_run();
  end

  initial begin
    int n;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 16'h6900, "R3", "reset readback", rd_data, 16'h6900);
    chk(!sys_rst_o && !irq_o && wr_ready, "R9", "reset outputs", {sys_rst_o, irq_o, wr_ready}, 3'b001);

    // R1 R10 R8: interval mode, tap 6, NMI bits set
    wr(16'h5A6F, 16'h696B, "R1");
    chk(nmi_en_o == 1'b1, "R10", "nmi_en", nmi_en_o, 1);
    chk(nmi_edge_o == 1'b1, "R10", "nmi_edge", nmi_edge_o, 1);
    until_irq(n);
    chk(n == 64, "R8", "interval expiry cycles", n, 64);
    chk(!sys_rst_o && !cause_expire_o, "R8", "no reset in interval mode", {sys_rst_o, cause_expire_o}, 0);
    ack();
    chk(irq_o == 1'b0, "R8", "irq after ack", irq_o, 0);
    until_irq(n);
    chk(n + 1 == 64, "R8", "restart after expiry", n + 1, 64);
    ack();

    // R5: hold
    wr(16'h5A7F, 16'h697B, "R5");
    repeat (300) @(posedge clk);
    #1;
    chk(irq_o == 1'b0, "R5", "no expiry while held", irq_o, 0);
    wr(16'h5A6B, 16'h696B, "R5");
    until_irq(n);
    chk(n == 64, "R5", "resume after hold", n, 64);
    ack();

    // R6: other taps
    wr(16'h5A0D, 16'h6909, "R6");
    chk(nmi_en_o == 1'b0 && nmi_edge_o == 1'b0, "R10", "nmi bits cleared", {nmi_en_o, nmi_edge_o}, 0);
    until_irq(n);
    chk(n == 8192, "R6", "tap 13 interval", n, 8192);
    ack();
    wr(16'h5A0E, 16'h690A, "R6");
    until_irq(n);
    chk(n == 512, "R6", "tap 9 interval", n, 512);
    ack();

    // R4: clear restarts the count
    wr(16'h5A0F, 16'h690B, "R4");
    repeat (40) @(posedge clk);
    wr(16'h5A0F, 16'h690B, "R4");
    until_irq(n);
    chk(n == 64, "R4", "count from second clear", n, 64);
    ack();

    // R7 R9 R11: watchdog expiry
    wr(16'h5A07, 16'h6903, "R7");
    until_rst(n);
    chk(n == 64, "R7", "watchdog expiry cycles", n, 64);
    chk(cause_expire_o && !cause_key_o, "R7", "expiry cause", {cause_expire_o, cause_key_o}, 2'b10);
    chk(wr_ready == 1'b0, "R11", "ready during pulse", wr_ready, 0);
    chk(irq_o == 1'b0, "R7", "no irq in watchdog mode", irq_o, 0);
    @(posedge clk);
    #1;
    chk(sys_rst_o == 1'b0, "R9", "pulse width", sys_rst_o, 0);
    chk(rd_data == 16'h6900, "R9", "control after pulse", rd_data, 16'h6900);

    // R2: wrong key
    wr(16'h5A6F, 16'h696B, "R2");
    wr(16'hA56F, 16'h696B, "R2");
    chk(sys_rst_o == 1'b1, "R2", "reset on bad key", sys_rst_o, 1);
    chk(cause_key_o == 1'b1, "R2", "key cause", cause_key_o, 1);
    @(posedge clk);
    #1;
    chk(sys_rst_o == 1'b0, "R9", "bad key pulse width", sys_rst_o, 0);
    chk(nmi_en_o == 1'b0 && rd_data == 16'h6900, "R9", "zeroed after bad key", rd_data, 16'h6900);
    chk(cause_expire_o == 1'b1, "R11", "expiry cause kept", cause_expire_o, 1);

    // R6: longest interval in watchdog mode
    wr(16'h5A04, 16'h6900, "R6");
    until_rst(n);
    chk(n == 32768, "R6", "tap 15 interval", n, 32768);
    @(posedge clk);
    #1;

    // R11: power-on reset clears causes
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!cause_key_o && !cause_expire_o, "R11", "causes after power-on reset", {cause_key_o, cause_expire_o}, 0);
    chk(rd_data[15:8] == 8'h69, "R3", "signature", rd_data[15:8], 8'h69);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule